// File: doc/BRIEF.md
# Memory Controller Configuration Register File

This block holds the configuration and status registers of an SDRAM controller and makes them reachable through only two register numbers on a simple processor control bus. One register number stores an offset pointer. The other is a data window that reads or writes whichever internal register the pointer currently selects. Software first writes the pointer, then reads or writes the window.

Each internal register applies its own write rule: a fixed mask, a write-one-to-clear rule, or forced bits. Writes to the configuration register also have side effects. When the enable bit changes, the status register and the activation of the memory banks follow it. When an auxiliary mode bit changes, a status bit mirrors the change. A nonzero ECC error status drives a level interrupt.

The bus is single-cycle. A request with `we` high writes in the cycle it is presented. A request with `we` low returns registered read data one cycle later, with `rvalid` high for that one cycle. There is no back-pressure: every request is accepted in the cycle it is presented.

Top module: `memctl_cfg_regs`

## Requirements
- R1: Register number 0x010 holds a 32-bit pointer, and a read of 0x010 returns it. A read of 0x011 returns the register the pointer selects. A read of any other register number returns zero. Read data and `rvalid` appear in the cycle after the request.
- R2: After reset, configuration reads 0x00800000, refresh timer reads 0x05F00000 and idle timer reads 0x07C00000. The `timing_cfg` output is 0x00854009. The pointer, status, bank registers, error registers and ECC registers are zero, and `ecc_irq` is low.
- R3: A window write to offset 0x00 or 0x08 (the error syndrome registers) clears each bit that is one in the written value. Offset 0x10 (error address) takes the full written value.
- R4: A window write to offset 0x20 (configuration) keeps only bits 31:21 of the value. `ctrl_en` equals configuration bit 31.
- R5: Status (offset 0x24) bit 31 is cleared when configuration bit 31 goes from 0 to 1, and set when it goes from 1 to 0. Writes to the status offset change nothing.
- R6: Status bit 30 is set when configuration bit 30 goes from 0 to 1, and cleared when it goes from 1 to 0. Both status bits are updated when a single configuration write changes both configuration bits.
- R7: Writes are masked as follows: refresh timer (0x30) with 0x3FF80000, timing (0x80, seen on `timing_cfg`) with 0x018FC01F, and ECC configuration (0x94) with 0x00F00000. The idle timer (0x34) takes bits 31:27 from the write and always reads ones in bits 26:22.
- R8: Bank register i sits at offset 0x40+4*i and keeps the written value masked with 0xFFDEE001. It appears on `bank_cfg[32*i +: 32]`. `bank_active[i]` is high exactly when `ctrl_en` is high and bank bit 0 is one.
- R9: ECC error status (0x98) keeps the write masked with 0xFFF0F000. `ecc_irq` goes high after a write leaves it nonzero and goes low after a write leaves it zero.
- R10: A window read of the timing offset, or of any offset not listed here, returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Bus request, one cycle per access |
| we | input | 1 | Write (1) or read (0) |
| regnum | input | RN_W | Bus register number |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| ctrl_en | output | 1 | Controller enable |
| bank_active | output | NUM_BANKS | Per-bank active (enabled and valid) |
| bank_cfg | output | 32*NUM_BANKS | Bank configuration registers |
| timing_cfg | output | 32 | Timing register |
| ecc_irq | output | 1 | ECC error interrupt level |

## Verification
Two effects can fall on one configuration write: the enable transition, which updates status bit 31 and gates every bank's active output, and the mode-bit transition, which updates status bit 30. Directed writes flip both configuration bits in one access in each direction. The bench then judges the status readback against both rules, and `bank_active` against the bank valid bits that were set before the write. Random traffic over all offsets, including unmapped ones, is compared against a bench model after every access.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;
  localparam int unsigned DW = 32;

  // bus register numbers
  localparam int unsigned PTR_REGNUM = 'h010;
  localparam int unsigned WIN_REGNUM = 'h011;

  // internal offsets
  localparam logic [DW-1:0] OFS_SYN0  = 32'h00;
  localparam logic [DW-1:0] OFS_SYN1  = 32'h08;
  localparam logic [DW-1:0] OFS_EADDR = 32'h10;
  localparam logic [DW-1:0] OFS_CFG   = 32'h20;
  localparam logic [DW-1:0] OFS_STAT  = 32'h24;
  localparam logic [DW-1:0] OFS_RTR   = 32'h30;
  localparam logic [DW-1:0] OFS_IDLE  = 32'h34;
  localparam logic [DW-1:0] OFS_BANK  = 32'h40;
  localparam logic [DW-1:0] OFS_TIM   = 32'h80;
  localparam logic [DW-1:0] OFS_ECFG  = 32'h94;
  localparam logic [DW-1:0] OFS_EESR  = 32'h98;

  // write masks
  localparam logic [DW-1:0] CFG_MASK   = 32'hFFE0_0000;
  localparam logic [DW-1:0] RTR_MASK   = 32'h3FF8_0000;
  localparam logic [DW-1:0] IDLE_MASK  = 32'hF800_0000;
  localparam logic [DW-1:0] IDLE_FORCE = 32'h07C0_0000;
  localparam logic [DW-1:0] TIM_MASK   = 32'h018F_C01F;
  localparam logic [DW-1:0] ECFG_MASK  = 32'h00F0_0000;
  localparam logic [DW-1:0] EESR_MASK  = 32'hFFF0_F000;
  localparam logic [DW-1:0] BANK_MASK  = 32'hFFDE_E001;

  // reset values
  localparam logic [DW-1:0] CFG_RST  = 32'h0080_0000;
  localparam logic [DW-1:0] RTR_RST  = 32'h05F0_0000;
  localparam logic [DW-1:0] IDLE_RST = 32'h07C0_0000;
  localparam logic [DW-1:0] TIM_RST  = 32'h0085_4009;

  localparam logic [DW-1:0] RD_MISS = 32'hFFFF_FFFF;

  typedef struct packed {
    logic syn0;
    logic syn1;
    logic eaddr;
    logic cfg;
    logic stat;
    logic rtr;
    logic idle;
    logic tim;
    logic ecfg;
    logic eesr;
  } sel_t;
endpackage

// File: rtl/memcfg_decode.sv
module memcfg_decode
  import memcfg_pkg::*;
#(
  parameter int unsigned NB = 4
) (
  input  logic [DW-1:0] ptr,
  output sel_t          sel,
  output logic [NB-1:0] bank_sel,
  output logic          hit
);
  always_comb begin
    sel.syn0  = (ptr == OFS_SYN0);
    sel.syn1  = (ptr == OFS_SYN1);
    sel.eaddr = (ptr == OFS_EADDR);
    sel.cfg   = (ptr == OFS_CFG);
    sel.stat  = (ptr == OFS_STAT);
    sel.rtr   = (ptr == OFS_RTR);
    sel.idle  = (ptr == OFS_IDLE);
    sel.tim   = (ptr == OFS_TIM);
    sel.ecfg  = (ptr == OFS_ECFG);
    sel.eesr  = (ptr == OFS_EESR);
  end

  for (genvar i = 0; i < NB; i++) begin : g_bsel
    localparam logic [DW-1:0] BOFS = OFS_BANK + DW'(4 * i);
    assign bank_sel[i] = (ptr == BOFS);
  end

  assign hit = (|sel) | (|bank_sel);
endmodule

// File: rtl/memcfg_cfg_status.sv
module memcfg_cfg_status
  import memcfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cfg,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cfg_q,
  output logic [DW-1:0] status_q
);
  logic [DW-1:0] cfg_nx;
  logic          st_en_q, st_mode_q;

  assign cfg_nx = wdata & CFG_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= CFG_RST;
      st_en_q   <= 1'b0;
      st_mode_q <= 1'b0;
    end else if (wr_cfg) begin
      cfg_q <= cfg_nx;
      // enable edge: status 31 marks the controller as idle/disabled
      if (!cfg_q[31] && cfg_nx[31])      st_en_q <= 1'b0;
      else if (cfg_q[31] && !cfg_nx[31]) st_en_q <= 1'b1;
      // mode edge: status 30 mirrors the transition
      if (!cfg_q[30] && cfg_nx[30])      st_mode_q <= 1'b1;
      else if (cfg_q[30] && !cfg_nx[30]) st_mode_q <= 1'b0;
    end
  end

  assign status_q = {st_en_q, st_mode_q, {(DW-2){1'b0}}};
endmodule

// File: rtl/memcfg_bank_regs.sv
module memcfg_bank_regs
  import memcfg_pkg::*;
#(
  parameter int unsigned NB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [NB-1:0]    bank_sel,
  input  logic [DW-1:0]    wdata,
  input  logic             ctrl_en,
  output logic [NB*DW-1:0] bank_q,
  output logic [NB-1:0]    bank_active
);
  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic [DW-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                r_q <= '0;
      else if (wr && bank_sel[i]) r_q <= wdata & BANK_MASK;
    end
    assign bank_q[i*DW +: DW] = r_q;
    assign bank_active[i]     = ctrl_en & r_q[0];
  end
endmodule

// File: rtl/memctl_cfg_regs.sv
module memctl_cfg_regs
  import memcfg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned RN_W      = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic                    we,
  input  logic [RN_W-1:0]         regnum,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  output logic                    rvalid,
  output logic                    ctrl_en,
  output logic [NUM_BANKS-1:0]    bank_active,
  output logic [NUM_BANKS*32-1:0] bank_cfg,
  output logic [31:0]             timing_cfg,
  output logic                    ecc_irq
);
  localparam logic [RN_W-1:0] PTR_RN = RN_W'(PTR_REGNUM);
  localparam logic [RN_W-1:0] WIN_RN = RN_W'(WIN_REGNUM);

  logic          ptr_hit, win_hit, wr_ptr, wr_win, rd_req;
  logic [DW-1:0] ptr_q, syn0_q, syn1_q, eaddr_q, rtr_q, idle_q, tim_q, ecfg_q, eesr_q;
  logic [DW-1:0] cfg_q, status_q, win_rd, eesr_nx;
  logic          irq_q;
  sel_t          sel;
  logic [NUM_BANKS-1:0] bank_sel;
  logic          dec_hit;

  assign ptr_hit = (regnum == PTR_RN);
  assign win_hit = (regnum == WIN_RN);
  assign wr_ptr  = req & we & ptr_hit;
  assign wr_win  = req & we & win_hit;
  assign rd_req  = req & ~we;

  memcfg_decode #(.NB(NUM_BANKS)) u_dec (
    .ptr(ptr_q), .sel(sel), .bank_sel(bank_sel), .hit(dec_hit)
  );

  memcfg_cfg_status u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_cfg(wr_win & sel.cfg), .wdata(wdata),
    .cfg_q(cfg_q), .status_q(status_q)
  );

  assign ctrl_en = cfg_q[31];

  memcfg_bank_regs #(.NB(NUM_BANKS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(wr_win), .bank_sel(bank_sel), .wdata(wdata),
    .ctrl_en(ctrl_en), .bank_q(bank_cfg), .bank_active(bank_active)
  );

  assign eesr_nx = wdata & EESR_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      syn0_q  <= '0;
      syn1_q  <= '0;
      eaddr_q <= '0;
      rtr_q   <= RTR_RST;
      idle_q  <= IDLE_RST;
      tim_q   <= TIM_RST;
      ecfg_q  <= '0;
      eesr_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_ptr) ptr_q <= wdata;
      if (wr_win) begin
        if (sel.syn0)  syn0_q  <= syn0_q & ~wdata;
        if (sel.syn1)  syn1_q  <= syn1_q & ~wdata;
        if (sel.eaddr) eaddr_q <= wdata;
        if (sel.rtr)   rtr_q   <= wdata & RTR_MASK;
        if (sel.idle)  idle_q  <= (wdata & IDLE_MASK) | IDLE_FORCE;
        if (sel.tim)   tim_q   <= wdata & TIM_MASK;
        if (sel.ecfg)  ecfg_q  <= wdata & ECFG_MASK;
        if (sel.eesr) begin
          eesr_q <= eesr_nx;
          irq_q  <= |eesr_nx;
        end
      end
    end
  end

  assign timing_cfg = tim_q;
  assign ecc_irq    = irq_q;

  always_comb begin
    win_rd = RD_MISS;
    if (dec_hit) begin
      unique case (1'b1)
        sel.syn0:  win_rd = syn0_q;
        sel.syn1:  win_rd = syn1_q;
        sel.eaddr: win_rd = eaddr_q;
        sel.cfg:   win_rd = cfg_q;
        sel.stat:  win_rd = status_q;
        sel.rtr:   win_rd = rtr_q;
        sel.idle:  win_rd = idle_q;
        sel.ecfg:  win_rd = ecfg_q;
        sel.eesr:  win_rd = eesr_q;
        default:   win_rd = RD_MISS;
      endcase
      for (int i = 0; i < NUM_BANKS; i++)
        if (bank_sel[i]) win_rd = bank_cfg[i*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_req;
      if (rd_req) rdata <= ptr_hit ? ptr_q : (win_hit ? win_rd : '0);
    end
  end
endmodule

// File: rtl/memcfg_chk.sv
module memcfg_chk
  import memcfg_pkg::*;
#(
  parameter int unsigned NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          we,
  input logic          rvalid,
  input logic          ctrl_en,
  input logic          ecc_irq,
  input logic [NB-1:0] bank_active,
  input logic [31:0]   status_q,
  input logic [31:0]   timing_cfg
);
  // R1
  rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(req && !we));

  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && we) |=> $stable(ctrl_en));

  // R5
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_en) |-> !status_q[31]);

  // R5
  en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_en) |-> status_q[31]);

  // R8
  bank_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_active) |-> ctrl_en);

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ecc_irq) |-> $past(req && we));

  // R7
  tim_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_cfg & ~TIM_MASK) == 32'h0);
endmodule

bind memctl_cfg_regs memcfg_chk #(.NB(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .rvalid(rvalid),
  .ctrl_en(ctrl_en), .ecc_irq(ecc_irq), .bank_active(bank_active),
  .status_q(status_q), .timing_cfg(timing_cfg)
);

// File: tb/memctl_cfg_regs_tb.sv
module memctl_cfg_regs_tb;
  localparam int NB = 4;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [9:0] regnum = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, timing_cfg;
  logic rvalid, ctrl_en, ecc_irq;
  logic [NB-1:0] bank_active;
  logic [NB*32-1:0] bank_cfg;

  int total = 0, bad = 0;

  // model state
  logic [31:0] m_ptr, m_eaddr, m_cfg, m_stat, m_rtr, m_idle, m_tim, m_ecfg, m_eesr;
  logic [31:0] m_bank [NB];

  always #4 clk = ~clk;

  memctl_cfg_regs #(.NUM_BANKS(NB), .RN_W(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .regnum(regnum), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .ctrl_en(ctrl_en), .bank_active(bank_active),
    .bank_cfg(bank_cfg), .timing_cfg(timing_cfg), .ecc_irq(ecc_irq)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_win(input logic [31:0] p);
    if (p == 32'h00 || p == 32'h08) return 32'h0;      // R3
    if (p == 32'h10) return m_eaddr;
    if (p == 32'h20) return m_cfg;
    if (p == 32'h24) return m_stat;
    if (p == 32'h30) return m_rtr;
    if (p == 32'h34) return m_idle;
    if (p == 32'h94) return m_ecfg;
    if (p == 32'h98) return m_eesr;
    for (int i = 0; i < NB; i++)
      if (p == 32'h40 + 32'(4 * i)) return m_bank[i];
    return 32'hFFFF_FFFF;                              // R10
  endfunction

  function automatic void model_wr(input logic [9:0] rn, input logic [31:0] d);
    logic [31:0] nv;
    if (rn == 10'h010) m_ptr = d;
    else if (rn == 10'h011) begin
      if (m_ptr == 32'h10) m_eaddr = d;
      else if (m_ptr == 32'h20) begin
        nv = d & 32'hFFE0_0000;
        if (!m_cfg[31] && nv[31]) m_stat[31] = 1'b0;
        else if (m_cfg[31] && !nv[31]) m_stat[31] = 1'b1;
        if (!m_cfg[30] && nv[30]) m_stat[30] = 1'b1;
        else if (m_cfg[30] && !nv[30]) m_stat[30] = 1'b0;
        m_cfg = nv;
      end
      else if (m_ptr == 32'h30) m_rtr = d & 32'h3FF8_0000;
      else if (m_ptr == 32'h34) m_idle = (d & 32'hF800_0000) | 32'h07C0_0000;
      else if (m_ptr == 32'h80) m_tim = d & 32'h018F_C01F;
      else if (m_ptr == 32'h94) m_ecfg = d & 32'h00F0_0000;
      else if (m_ptr == 32'h98) m_eesr = d & 32'hFFF0_F000;
      for (int i = 0; i < NB; i++)
        if (m_ptr == 32'h40 + 32'(4 * i)) m_bank[i] = d & 32'hFFDE_E001;
    end
  endfunction

  function automatic logic [31:0] exp_rd(input logic [9:0] rn);
    if (rn == 10'h010) return m_ptr;
    if (rn == 10'h011) return exp_win(m_ptr);
    return 32'h0;
  endfunction

  task automatic check_outs();
    logic [NB-1:0] act_exp;
    for (int i = 0; i < NB; i++) act_exp[i] = m_cfg[31] & m_bank[i][0];
    chk("R4 ctrl_en", {31'b0, ctrl_en}, {31'b0, m_cfg[31]});
    chk("R8 bank_active", 32'(bank_active), 32'(act_exp));
    for (int i = 0; i < NB; i++) chk("R8 bank_cfg", bank_cfg[i*32 +: 32], m_bank[i]);
    chk("R7 timing_cfg", timing_cfg, m_tim);
    chk("R9 ecc_irq", {31'b0, ecc_irq}, {31'b0, (m_eesr != 0)});
  endtask

  task automatic wr(input logic [9:0] rn, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; regnum = rn; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
    model_wr(rn, d);
    check_outs();
  endtask

  task automatic rd(input logic [9:0] rn, input string rq);
    @(negedge clk); req = 1'b1; we = 1'b0; regnum = rn;
    @(negedge clk); req = 1'b0;
    chk("R1 rvalid", {31'b0, rvalid}, 32'h1);
    chk(rq, rdata, exp_rd(rn));
  endtask

  task automatic wwin(input logic [31:0] ofs, input logic [31:0] d);
    wr(10'h010, ofs); wr(10'h011, d);
  endtask

  task automatic rwin(input logic [31:0] ofs, input string rq);
    wr(10'h010, ofs); rd(10'h011, rq);
  endtask

  initial begin
    #(8 * 190000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] ofs_list [17];
    void'($urandom(32'd20240611));
    m_ptr = 0; m_eaddr = 0; m_cfg = 32'h0080_0000; m_stat = 0;
    m_rtr = 32'h05F0_0000; m_idle = 32'h07C0_0000; m_tim = 32'h0085_4009;
    m_ecfg = 0; m_eesr = 0;
    for (int i = 0; i < NB; i++) m_bank[i] = 0;
    ofs_list = '{32'h00, 32'h08, 32'h10, 32'h20, 32'h24, 32'h30, 32'h34, 32'h40,
                 32'h44, 32'h48, 32'h4C, 32'h80, 32'h94, 32'h98, 32'h04, 32'h84, 32'h120};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    chk("R2 rvalid idle", {31'b0, rvalid}, 32'h0);
    chk("R2 timing_cfg", timing_cfg, 32'h0085_4009);
    chk("R2 ecc_irq", {31'b0, ecc_irq}, 32'h0);
    rd(10'h010, "R2 pointer");
    rwin(32'h20, "R2 cfg");
    rwin(32'h30, "R2 refresh");
    rwin(32'h34, "R2 idle");
    rwin(32'h24, "R2 status");

    // R1 other register numbers read zero
    rd(10'h155, "R1 other regnum");
    // R10 timing and unmapped read all ones
    rwin(32'h80, "R10 timing read");
    rwin(32'h3C, "R10 unmapped");

    // R8 banks valid while disabled, then R6/R5 same-cycle config edges
    wwin(32'h40, 32'hFFFF_FFFF);
    wwin(32'h48, 32'h1234_5679);
    chk("R8 inactive while disabled", 32'(bank_active), 32'h0);
    wwin(32'h20, 32'hC000_0000);
    rd(10'h011, "R6 R5 both rise");
    chk("R6 status after rise", exp_win(32'h24) & 32'hC000_0000, 32'h4000_0000);
    wwin(32'h24, 32'hFFFF_FFFF);
    rd(10'h011, "R5 status ignores write");
    wwin(32'h20, 32'h0000_0000);
    rwin(32'h24, "R6 R5 both fall");
    chk("R8 inactive after disable", 32'(bank_active), 32'h0);

    // R3 W1C and error address
    wwin(32'h00, 32'hFFFF_FFFF);
    rd(10'h011, "R3 syndrome0");
    wwin(32'h08, 32'hA5A5_A5A5);
    rd(10'h011, "R3 syndrome1");
    wwin(32'h10, 32'hDEAD_BEEF);
    rd(10'h011, "R3 error address");

    // R9 irq both edges
    wwin(32'h98, 32'h000F_0FFF);
    chk("R9 masked to zero", {31'b0, ecc_irq}, 32'h0);
    wwin(32'h98, 32'h0000_1000);
    rd(10'h011, "R9 eesr");
    wwin(32'h98, 32'h0);

    // R7 masks
    wwin(32'h34, 32'h0000_0000);
    rd(10'h011, "R7 idle forced");
    wwin(32'h30, 32'hFFFF_FFFF);
    rd(10'h011, "R7 refresh mask");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int k;
      logic [31:0] v;
      k = int'($urandom_range(16, 0));
      v = $urandom;
      if (($urandom & 3) == 0) v[31:30] = 2'(n);
      case ($urandom_range(3, 0))
        0: wr(10'h010, ofs_list[k]);
        1: wr(10'h011, v);
        2: rd(10'h011, "R1 R3 R4 R7 R8 R9 R10 random window");
        default: rd(10'h010, "R1 random pointer");
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule